// File: doc/BRIEF.md
# Issue-Queue Driven Clock Speed Governor

This block sets the operating speed of one locally clocked island of an out-of-order core. It looks at how full the island's issue queue is, and only at fixed sampling points. When the queue is filling up, it selects the fast mode. When the queue is nearly empty, it selects the slow mode. Between two programmable thresholds it keeps the current mode, so the mode does not flip back and forth when the occupancy hovers near one level.

A queue can also run low because a neighbouring island is holding back this one. In that case the low reading does not mean the island has spare time. A stall flag from the neighbour blocks any slowdown while it is raised.

Each mode change raises a single-cycle request toward the clock and voltage control. After that, the block ignores further decisions until a programmable settle time has passed. The thresholds, the sampling interval and the settle time are captured from configuration pins while reset is held. Typical pairs are 9/12 for integer and memory islands and 6/9 for floating-point islands.

Top module: `spd_gov`

## Requirements
- R1: During and directly after reset, `mode_lo` is 0 (fast mode), `freq_code` is 8, `chg_req` is 0 and `settling` is 0.
- R2: At a sampling point, an occupancy equal to or greater than the upper threshold selects fast mode (`mode_lo` = 0).
- R3: At a sampling point, an occupancy equal to or less than the lower threshold, with `xdom_stall` low, selects slow mode (`mode_lo` = 1).
- R4: At a sampling point, an occupancy strictly between the two thresholds leaves the mode unchanged.
- R5: While `xdom_stall` is 1, a low occupancy does not select slow mode. A high occupancy still selects fast mode.
- R6: Occupancy is evaluated only on every IVL-th cycle after reset, where IVL is the interval captured at reset (0 is treated as 1). Sampling points fall on cycles IVL-1, 2·IVL-1, and so on, counting from 0 at the first cycle out of reset. Occupancy values in other cycles have no effect.
- R7: A mode change is signalled by `chg_req` = 1 for exactly one cycle: the cycle in which the new mode first appears on `mode_lo`. `chg_req` stays 0 when no change occurs.
- R8: After a change, `settling` is 1 for exactly S cycles, where S is the settle count captured at reset. The first of these cycles is the one with `chg_req` high. Sampling points that fall while `settling` is 1 are ignored.
- R9: `freq_code` is 8 in fast mode and 6 in slow mode, in units of 125 MHz (1 GHz and 750 MHz).
- R10: The configuration inputs are captured only while `rst` is 1. Changing them after reset has no effect on the behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Island clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while it is high |
| occ | input | 6 | Current issue-queue occupancy, 0 to 32 |
| xdom_stall | input | 1 | A neighbouring island is stalling this one |
| cfg_lo_thr | input | 6 | Lower occupancy threshold |
| cfg_hi_thr | input | 6 | Upper occupancy threshold |
| cfg_ivl | input | 16 | Sampling interval in cycles |
| cfg_settle | input | 16 | Hold-off cycles after a change |
| mode_lo | output | 1 | 1 = slow mode, 0 = fast mode |
| freq_code | output | 4 | Frequency level, in units of 125 MHz |
| chg_req | output | 1 | One-cycle request for a clock/voltage change |
| settling | output | 1 | A change is still settling |

## Verification
The governor is driven with several occupancy patterns, each held over several sampling points:
- A high occupancy, which tells the fast-select path apart.
- A mid-band occupancy in each mode, which separates hysteresis from plain one-threshold switching.
- A low occupancy with the stall flag raised and then dropped, which isolates the veto.
- Occupancies exactly at both thresholds, which expose off-by-one comparisons.
- A one-cycle high spike placed between sampling points, which shows whether the input is read every cycle.
- A reversal forced inside the settle window, which shows whether the hold-off is honoured.
- Configuration pins altered after reset, which reveal any capture outside reset.

// File: rtl/spd_gov_pkg.sv
package spd_gov_pkg;

    localparam int OCC_W  = 6;
    localparam int CNT_W  = 16;
    localparam int FREQ_W = 4;

    // frequency levels in 125 MHz steps
    localparam logic [FREQ_W-1:0] FREQ_FAST = 4'd8;
    localparam logic [FREQ_W-1:0] FREQ_SLOW = 4'd6;

    typedef enum logic {
        SPD_HIGH = 1'b0,
        SPD_LOW  = 1'b1
    } spd_mode_e;

    typedef struct packed {
        logic [OCC_W-1:0] lo_thr;
        logic [OCC_W-1:0] hi_thr;
        logic [CNT_W-1:0] ivl;
        logic [CNT_W-1:0] settle;
    } spd_cfg_t;

    function automatic logic [FREQ_W-1:0] freq_of(spd_mode_e m);
        return (m == SPD_HIGH) ? FREQ_FAST : FREQ_SLOW;
    endfunction

endpackage

// File: rtl/spd_sample_timer.sv
module spd_sample_timer
    import spd_gov_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ivl,
    output logic         tick
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] last;

    // an interval of zero behaves as one
    assign last = (ivl == '0) ? '0 : ivl - 1'b1;
    assign tick = (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && last != '0) |=> !tick);

endmodule

// File: rtl/spd_decide.sv
module spd_decide
    import spd_gov_pkg::*;
#(
    parameter int W = OCC_W
) (
    input  logic [W-1:0] occ,
    input  logic [W-1:0] lo_thr,
    input  logic [W-1:0] hi_thr,
    input  logic         stall,
    input  spd_mode_e    cur,
    output spd_mode_e    want
);
    always_comb begin
        if (occ >= hi_thr)                want = SPD_HIGH;
        else if (occ <= lo_thr && !stall) want = SPD_LOW;
        else                              want = cur;
    end
endmodule

// File: rtl/spd_settle.sv
module spd_settle
    import spd_gov_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         busy
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= len;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    assert_settle_start_R8: assert property (@(posedge clk) disable iff (rst)
        (load && len != '0) |=> busy);

endmodule

// File: rtl/spd_gov.sv
module spd_gov
    import spd_gov_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OCC_W-1:0]  occ,
    input  logic              xdom_stall,
    input  logic [OCC_W-1:0]  cfg_lo_thr,
    input  logic [OCC_W-1:0]  cfg_hi_thr,
    input  logic [CNT_W-1:0]  cfg_ivl,
    input  logic [CNT_W-1:0]  cfg_settle,
    output logic              mode_lo,
    output logic [FREQ_W-1:0] freq_code,
    output logic              chg_req,
    output logic              settling
);
    spd_cfg_t  cfg_q;
    spd_mode_e mode_q;
    spd_mode_e want;
    logic      tick;
    logic      busy;
    logic      apply;
    logic      chg_q;

    // configuration is captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.lo_thr <= cfg_lo_thr;
            cfg_q.hi_thr <= cfg_hi_thr;
            cfg_q.ivl    <= cfg_ivl;
            cfg_q.settle <= cfg_settle;
        end
    end

    spd_sample_timer #(.W(CNT_W)) u_tmr (
        .clk (clk),
        .rst (rst),
        .ivl (cfg_q.ivl),
        .tick(tick)
    );

    spd_decide #(.W(OCC_W)) u_dec (
        .occ   (occ),
        .lo_thr(cfg_q.lo_thr),
        .hi_thr(cfg_q.hi_thr),
        .stall (xdom_stall),
        .cur   (mode_q),
        .want  (want)
    );

    assign apply = tick && !busy && (want != mode_q);

    spd_settle #(.W(CNT_W)) u_stl (
        .clk (clk),
        .rst (rst),
        .load(apply),
        .len (cfg_q.settle),
        .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SPD_HIGH;
            chg_q  <= 1'b0;
        end else begin
            chg_q <= apply;
            if (apply) mode_q <= want;
        end
    end

    assign mode_lo   = (mode_q == SPD_LOW);
    assign freq_code = freq_of(mode_q);
    assign chg_req   = chg_q;
    assign settling  = busy;

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
        chg_req |=> !chg_req);

    assert_change_flagged_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && !busy && want != mode_q) |=> chg_req);

    assert_hold_while_settling_R8: assert property (@(posedge clk) disable iff (rst)
        settling |=> $stable(mode_lo));

    assert_stall_veto_R5: assert property (@(posedge clk) disable iff (rst)
        (xdom_stall && occ < cfg_q.hi_thr) |=> $stable(mode_lo));

    assert_offtick_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(mode_lo));

endmodule

// File: tb/sim_spd_gov.sv
module sim_spd_gov;
    localparam int LO = 9, HI = 12, IVL = 4, STL = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  occ = 6'd0;
    logic        xdom_stall = 1'b0;
    logic [5:0]  cfg_lo_thr = 6'(LO);
    logic [5:0]  cfg_hi_thr = 6'(HI);
    logic [15:0] cfg_ivl    = 16'(IVL);
    logic [15:0] cfg_settle = 16'(STL);
    logic        mode_lo;
    logic [3:0]  freq_code;
    logic        chg_req;
    logic        settling;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;
    string phase = "R1";

    // reference model state
    int  m_cyc = 0;
    int  m_cnt = 0;
    bit  m_low = 1'b0;
    bit  m_chg = 1'b0;
    bit  sb_q[$];

    always #10 clk = ~clk;  // 50 MHz

    spd_gov u0 (
        .clk(clk), .rst(rst), .occ(occ), .xdom_stall(xdom_stall),
        .cfg_lo_thr(cfg_lo_thr), .cfg_hi_thr(cfg_hi_thr),
        .cfg_ivl(cfg_ivl), .cfg_settle(cfg_settle),
        .mode_lo(mode_lo), .freq_code(freq_code),
        .chg_req(chg_req), .settling(settling)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // model built from the requirements; updates at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_cyc = 0; m_cnt = 0; m_low = 1'b0; m_chg = 1'b0;
        end else begin
            bit tick, want, apply;
            tick = ((m_cyc % IVL) == IVL - 1);
            if (occ >= HI)                   want = 1'b0;
            else if (occ <= LO && !xdom_stall) want = 1'b1;
            else                             want = m_low;
            apply = tick && (m_cnt == 0) && (want != m_low);
            if (apply) begin
                m_low = want;
                m_cnt = STL;
                sb_q.push_back(want);
            end else if (m_cnt != 0) begin
                m_cnt--;
            end
            m_chg = apply;
            m_cyc++;
        end
    end

    // monitor: compares the outputs against the model, away from the edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(mode_lo == m_low, phase, mode_lo, m_low);
            check(freq_code == (m_low ? 4'd6 : 4'd8), "R9", freq_code, m_low ? 6 : 8);
            check(chg_req == m_chg, "R7", chg_req, m_chg);
            check(settling == (m_cnt != 0), "R8", settling, m_cnt != 0);
            if (chg_req) begin
                if (sb_q.size() == 0) check(1'b0, "R7", 1, 0);
                else begin
                    bit e;
                    e = sb_q.pop_front();
                    check(mode_lo == e, "R7", mode_lo, e);
                end
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(3);
        // R1: reset values while held
        check(mode_lo == 1'b0 && chg_req == 1'b0 && settling == 1'b0, "R1", mode_lo, 0);
        check(freq_code == 4'd8, "R1", freq_code, 8);
        rst = 1'b0;
        // R10: scramble configuration after reset
        cfg_lo_thr = 6'd30; cfg_hi_thr = 6'd31; cfg_ivl = 16'd1; cfg_settle = 16'd0;
        @(negedge clk);
        check(mode_lo == 1'b0 && chg_req == 1'b0, "R1", mode_lo, 0);

        phase = "R2";  occ = 6'd20; run(12);
        phase = "R4";  occ = 6'd10; run(12);
        check(mode_lo == 1'b0, "R10", mode_lo, 0);  // scrambled lo=30 would have slowed
        phase = "R5";  occ = 6'd3; xdom_stall = 1'b1; run(16);
        check(mode_lo == 1'b0, "R5", mode_lo, 0);
        phase = "R3";  xdom_stall = 1'b0; run(16);
        check(mode_lo == 1'b1, "R3", mode_lo, 1);
        phase = "R4";  occ = 6'd10; run(12);
        check(mode_lo == 1'b1, "R4", mode_lo, 1);

        // R6: one-cycle spike placed between sampling points
        phase = "R6";
        while ((m_cyc % IVL) != 0) @(negedge clk);
        occ = 6'd20; @(negedge clk); occ = 6'd10; run(8);
        check(mode_lo == 1'b1, "R6", mode_lo, 1);

        // R2 at the exact upper threshold, then R8 reversal inside settle window
        phase = "R2"; occ = 6'd12;
        while (!chg_req) @(negedge clk);
        phase = "R8"; occ = 6'd9;
        run(3);
        check(mode_lo == 1'b0, "R8", mode_lo, 0);
        run(12);
        check(mode_lo == 1'b1, "R3", mode_lo, 1);  // lower threshold equality
        phase = "R2"; occ = 6'd32; run(12);
        check(mode_lo == 1'b0, "R2", mode_lo, 0);
        run(2);
        check(sb_q.size() == 0, "R7", sb_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule